// File: doc/BRIEF.md
# Five-Source Fixed-Rank Interrupt Controller

This block gathers five interrupt sources into one request toward a processor core. There are two external request pins, two timer overflow flags and a serial flag formed from the transmit-done and receive-done indications. Each external pin has its own mode bit. In edge mode the pin latches a request flag when it falls. In level mode the pin drives its request directly while it is held low, and nothing is stored.

A per-source enable mask and a global enable gate the sources. A fixed ranking then picks the single winner. The block drives `irq_req` with a 16-bit vector address for that winner. When the core takes the interrupt it pulses `irq_ack`. That clears the winner's latched edge or timer flag and marks the controller as busy. The core pulses `irq_done` when the handler finishes, and no further request is raised until then.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `irq_req` is 0, `irq_vec` is 0000h, and all edge and timer flags read 0.
- R2: With `ext_mode[k]`=1 (edge mode), a high-then-low pin transition between two consecutive clock samples sets `edge_flag[k]` at the next clock edge. A pin that stays low after its flag was cleared does not set the flag again.
- R3: With `ext_mode[k]`=0 (level mode), the request for external source k follows the pin without a clock (asserted while `ext_pin[k]` is 0), and `edge_flag[k]` is not set.
- R4: A one-cycle pulse on `tmr_ovf[k]` sets `tmr_flag[k]` at the next clock edge. The flag holds until the acknowledge that selects that timer.
- R5: The serial source requests while `ser_tx_done` or `ser_rx_done` is 1, and an acknowledge does not remove it.
- R6: `src_en` bit r masks the source of rank r (0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial). A masked source still latches its flag and requests as soon as it is unmasked.
- R7: While `glob_en` is 0, `irq_req` stays 0 and latched flags are kept.
- R8: When several sources are pending, the winner is the lowest rank: ext0, then tmr0, then ext1, then tmr1, then serial.
- R9: `irq_vec` equals 0003h + 8 × rank of the winner (0003h, 000Bh, 0013h, 001Bh, 0023h) while `irq_req` is 1, and 0000h otherwise.
- R10: `irq_ack` while `irq_req` is 1 clears only the winner's edge or timer flag at the next clock edge. Flags of the other sources are unchanged.
- R11: After an accepted acknowledge, `irq_req` stays 0 until a clock edge with `irq_done` at 1. Pending sources are then presented again.
- R12: If a flag's set event and its clearing acknowledge fall on the same clock edge, the flag ends up set.
- R13: `irq_ack` while `irq_req` is 0 clears no flag and does not block later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External request pins, active low |
| ext_mode | input | 2 | Per-pin mode: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| src_en | input | 5 | Per-source enable, indexed by rank |
| glob_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_done | input | 1 | Handler finished, release busy state |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winner |
| edge_flag | output | 2 | Latched external edge flags |
| tmr_flag | output | 2 | Latched timer overflow flags |

## Verification
The case of interest is a flag's set event landing on the same clock edge as the acknowledge that clears it. This is tried for an external edge flag and for a timer flag. In the edge case, the pin is raised for one cycle after a first latched fall and then dropped again together with `irq_ack`. In the timer case, a new overflow pulse is driven in the acknowledge cycle. In both cases the flag must read 1 afterwards, `irq_req` must stay low while the controller is busy, and the same vector must be presented again right after `irq_done`.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned VEC_W = 16;

  // Vector address for a given rank: base plus a fixed stride per rank.
  function automatic logic [VEC_W-1:0] rank_vector(input logic [7:0] rank,
                                                   input logic [VEC_W-1:0] base,
                                                   input logic [VEC_W-1:0] step);
    return base + step * {{(VEC_W-8){1'b0}}, rank};
  endfunction

endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic clr,
  output logic flag,
  output logic req
);

  logic pin_d;
  logic fall;
  logic flag_nxt;
  logic flag_en;

  // Falling edge: previous sample high, present sample low.
  assign fall = edge_mode & pin_d & ~pin;

  always_comb begin
    flag_en  = fall | clr;
    flag_nxt = fall ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d <= 1'b1;
    end else begin
      pin_d <= pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_nxt;
    end
  end

  assign req = edge_mode ? flag : ~pin;

endmodule

// File: rtl/irq_tmr_src.sv
module irq_tmr_src (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_nxt;
  logic flag_en;

  always_comb begin
    flag_en  = set | clr;
    flag_nxt = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_nxt;
    end
  end

endmodule

// File: rtl/irq_rank_sel.sv
module irq_rank_sel #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_PAIR   = 2,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PAIR-1:0]         ext_pin,
  input  logic [N_PAIR-1:0]         ext_mode,
  input  logic [N_PAIR-1:0]         tmr_ovf,
  input  logic                      ser_tx_done,
  input  logic                      ser_rx_done,
  input  logic [2*N_PAIR:0]         src_en,
  input  logic                      glob_en,
  input  logic                      irq_ack,
  input  logic                      irq_done,
  output logic                      irq_req,
  output logic [15:0]               irq_vec,
  output logic [N_PAIR-1:0]         edge_flag,
  output logic [N_PAIR-1:0]         tmr_flag
);

  localparam int unsigned NUM_SRC = 2 * N_PAIR + 1;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned SER_R   = NUM_SRC - 1;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic               any;
  logic [IDX_W-1:0]   win;
  logic               take;
  logic               busy;
  logic               busy_nxt;
  logic               busy_en;

  // Ranks interleave: 2k is external k, 2k+1 is timer k, last is serial.
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    irq_ext_src u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin[p]),
      .edge_mode (ext_mode[p]),
      .clr       (clr[2*p]),
      .flag      (edge_flag[p]),
      .req       (raw[2*p])
    );

    irq_tmr_src u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tmr_ovf[p]),
      .clr   (clr[2*p+1]),
      .flag  (tmr_flag[p])
    );

    assign raw[2*p+1] = tmr_flag[p];
  end

  assign raw[SER_R] = ser_tx_done | ser_rx_done;

  assign pend = raw & src_en & {NUM_SRC{glob_en & ~busy}};

  irq_rank_sel #(
    .N     (NUM_SRC),
    .IDX_W (IDX_W)
  ) u_sel (
    .pend (pend),
    .any  (any),
    .idx  (win)
  );

  assign irq_req = any;
  assign irq_vec = any ? rank_vector(8'(win), VEC_BASE, VEC_STEP) : 16'h0000;
  assign take    = irq_ack & any;

  // Serial source has no hardware clear.
  always_comb begin
    clr = '0;
    for (int i = 0; i < NUM_SRC - 1; i++) begin
      clr[i] = take & (win == IDX_W'(i));
    end
  end

  always_comb begin
    busy_en  = take | irq_done;
    busy_nxt = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (busy_en) begin
      busy <= busy_nxt;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ext_pin,
  input logic [1:0]  ext_mode,
  input logic [4:0]  src_en,
  input logic        glob_en,
  input logic        irq_ack,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic [1:0]  edge_flag,
  input logic [1:0]  tmr_flag
);

  assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);

  assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 16'h0000));

  assert_vec_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[15:6] == 10'd0));

  assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode[0] && $past(ext_pin[0]) && !ext_pin[0]) |=> edge_flag[0]);

  assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);

  assert_tmr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag[1] && !(irq_ack && irq_req && irq_vec == 16'h001B)) |=> tmr_flag[1]);

  assert_top_rank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && ext_mode[0] && edge_flag[0] && src_en[0]) |-> (irq_vec == 16'h0003));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_pin   (ext_pin),
  .ext_mode  (ext_mode),
  .src_en    (src_en),
  .glob_en   (glob_en),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .edge_flag (edge_flag),
  .tmr_flag  (tmr_flag)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  ext_pin;
  logic [1:0]  ext_mode;
  logic [1:0]  tmr_ovf;
  logic        ser_tx_done;
  logic        ser_rx_done;
  logic [4:0]  src_en;
  logic        glob_en;
  logic        irq_ack;
  logic        irq_done;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [1:0]  edge_flag;
  logic [1:0]  tmr_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  irq_prio_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_pin     (ext_pin),
    .ext_mode    (ext_mode),
    .tmr_ovf     (tmr_ovf),
    .ser_tx_done (ser_tx_done),
    .ser_rx_done (ser_rx_done),
    .src_en      (src_en),
    .glob_en     (glob_en),
    .irq_ack     (irq_ack),
    .irq_done    (irq_done),
    .irq_req     (irq_req),
    .irq_vec     (irq_vec),
    .edge_flag   (edge_flag),
    .tmr_flag    (tmr_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic ack_only();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic release_busy();
    irq_done = 1'b1;
    tick();
    irq_done = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ext_pin = 2'b11; ext_mode = 2'b11; tmr_ovf = 2'b00;
    ser_tx_done = 1'b0; ser_rx_done = 1'b0; src_en = 5'b11111; glob_en = 1'b1;
    irq_ack = 1'b0; irq_done = 1'b0;
    tick(); tick();
    check("R1 req in reset", {15'd0, irq_req}, 16'd0);
    rst_n = 1'b1;
    tick();
    check("R1 vec after reset", irq_vec, 16'h0000);
    check("R1 flags after reset", {12'd0, edge_flag, tmr_flag}, 16'd0);
  endtask

  task automatic t_edge();
    src_en = 5'b00001; ext_mode[0] = 1'b1;
    ext_pin[0] = 1'b0; settle();
    check("R2 no flag before edge clock", {15'd0, edge_flag[0]}, 16'd0);
    tick();
    check("R2 flag set on fall", {15'd0, edge_flag[0]}, 16'd1);
    check("R9 vec ext0", irq_vec, 16'h0003);
    ack_only();
    check("R10 ext0 flag cleared", {15'd0, edge_flag[0]}, 16'd0);
    check("R11 busy blocks", {15'd0, irq_req}, 16'd0);
    tick();
    check("R11 still busy", {15'd0, irq_req}, 16'd0);
    release_busy();
    tick();
    check("R2 held low no retrigger", {15'd0, edge_flag[0]}, 16'd0);
    ext_pin[0] = 1'b1; tick();
  endtask

  task automatic t_level();
    src_en = 5'b00100; ext_mode[1] = 1'b0;
    ext_pin[1] = 1'b0; settle();
    check("R3 level req without clock", {15'd0, irq_req}, 16'd1);
    check("R9 vec ext1", irq_vec, 16'h0013);
    tick();
    check("R3 no flag in level mode", {15'd0, edge_flag[1]}, 16'd0);
    ext_pin[1] = 1'b1; settle();
    check("R3 level drops", {15'd0, irq_req}, 16'd0);
    tick();
  endtask

  task automatic t_timer();
    src_en = 5'b00010;
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0; settle();
    check("R4 timer flag set", {15'd0, tmr_flag[0]}, 16'd1);
    check("R9 vec tmr0", irq_vec, 16'h000B);
    tick(); tick();
    check("R4 timer flag holds", {15'd0, tmr_flag[0]}, 16'd1);
    ack_only();
    check("R4 timer flag cleared by ack", {15'd0, tmr_flag[0]}, 16'd0);
    release_busy();
    check("R4 no req after clear", {15'd0, irq_req}, 16'd0);
  endtask

  task automatic t_serial();
    src_en = 5'b10000;
    ser_tx_done = 1'b1; settle();
    check("R9 vec serial", irq_vec, 16'h0023);
    ack_only();
    release_busy();
    check("R5 serial kept after ack", {15'd0, irq_req}, 16'd1);
    ser_tx_done = 1'b0; ser_rx_done = 1'b1; settle();
    check("R5 rx requests", {15'd0, irq_req}, 16'd1);
    ser_rx_done = 1'b0; settle();
    check("R5 serial idle", {15'd0, irq_req}, 16'd0);
  endtask

  task automatic t_enable();
    src_en = 5'b00000;
    tmr_ovf[1] = 1'b1; tick(); tmr_ovf[1] = 1'b0; settle();
    check("R6 masked flag latched", {15'd0, tmr_flag[1]}, 16'd1);
    check("R6 masked no req", {15'd0, irq_req}, 16'd0);
    src_en = 5'b01000; settle();
    check("R6 unmasked vec tmr1", irq_vec, 16'h001B);
    ack_only(); release_busy();
  endtask

  task automatic t_global();
    glob_en = 1'b0; src_en = 5'b11111;
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0; tick();
    check("R7 global off no req", {15'd0, irq_req}, 16'd0);
    check("R7 flag kept", {15'd0, tmr_flag[0]}, 16'd1);
    glob_en = 1'b1; settle();
    check("R7 global on vec", irq_vec, 16'h000B);
    ack_only(); release_busy();
  endtask

  task automatic t_priority();
    src_en = 5'b11111; ext_mode = 2'b01;
    tmr_ovf = 2'b11; ser_tx_done = 1'b1; ext_pin = 2'b00;
    tick(); tmr_ovf = 2'b00; settle();
    check("R8 ext0 wins all", irq_vec, 16'h0003);
    ack_only();
    check("R10 others kept", {14'd0, tmr_flag}, 16'd3);
    release_busy();
    check("R8 tmr0 next", irq_vec, 16'h000B);
    ack_only(); release_busy();
    check("R8 ext1 next", irq_vec, 16'h0013);
    ext_pin[1] = 1'b1; settle();
    check("R8 tmr1 next", irq_vec, 16'h001B);
    ack_only(); release_busy();
    check("R8 serial last", irq_vec, 16'h0023);
    ser_tx_done = 1'b0; ext_pin[0] = 1'b1; ext_mode = 2'b11; tick();
    check("R8 all idle", {15'd0, irq_req}, 16'd0);
  endtask

  task automatic t_same_cycle();
    src_en = 5'b00001;
    ext_pin[0] = 1'b0; tick();
    ext_pin[0] = 1'b1; tick();
    ext_pin[0] = 1'b0; irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    check("R12 edge set beats clear", {15'd0, edge_flag[0]}, 16'd1);
    check("R12 busy after ack", {15'd0, irq_req}, 16'd0);
    release_busy();
    check("R12 ext0 presented again", irq_vec, 16'h0003);
    ack_only(); release_busy();
    ext_pin[0] = 1'b1; tick();
    src_en = 5'b00010;
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0;
    tmr_ovf[0] = 1'b1; irq_ack = 1'b1; tick(); tmr_ovf[0] = 1'b0; irq_ack = 1'b0;
    check("R12 timer set beats clear", {15'd0, tmr_flag[0]}, 16'd1);
    release_busy();
    check("R12 tmr0 presented again", irq_vec, 16'h000B);
    ack_only(); release_busy();
  endtask

  task automatic t_stray_ack();
    src_en = 5'b00000;
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0;
    ack_only();
    check("R13 stray ack keeps flag", {15'd0, tmr_flag[0]}, 16'd1);
    src_en = 5'b00010; settle();
    check("R13 stray ack not busy", {15'd0, irq_req}, 16'd1);
    ack_only(); release_busy();
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_timer();
    t_serial();
    t_enable();
    t_global();
    t_priority();
    t_same_cycle();
    t_stray_ack();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule